// File: doc/BRIEF.md
# Cartridge Bank Mapping Register Unit

This block is the bank-mapping logic of a cartridge for an 8-bit console. The CPU writes configuration bytes anywhere in the upper half of its address space. Four address bits pick one of sixteen byte-wide registers. From these registers the block forms the bank numbers for the following windows:

- two 4 KB work-RAM windows;
- four 8 KB program windows;
- two 4 KB pattern windows.

It also produces a nametable mirroring select and a small shadow code for the video side.

There are two program devices, one internal and one external. For each of the three switchable program windows, a device-select bit in its register chooses the device. The topmost program window is wired to the last bank of the external device. Work-RAM bank numbers are built by folding the lowest register bit together with the bits above bit 1. The storage arrays, battery handling and the nametable RAM itself are outside the block. All bank outputs are plain combinational functions of the stored registers. A write therefore becomes visible in the cycle after the clock edge that stores it.

Top module: `cart_bank_map`

## Requirements
- R1: A write with `cpu_wr` high and `cpu_addr[15]` high stores `cpu_data` into register `cpu_addr[11:8]` at the clock edge. Writes to registers 6-9 and 11-15 change no output.
- R2: The work-RAM bank for the lower window comes from register 0, and the bank for the upper window comes from register 1. Each bank is `((r & 1) | (r >> 2))` truncated to 2 bits, so bit 0 is `r[0]|r[2]` and bit 1 is `r[3]`.
- R3: Program windows 0, 1 and 2 take their 6-bit bank from bits [5:0] of registers 2, 3 and 4. They take the device select from bit 6 of the same register (1 = external, 0 = internal). Bit 7 has no effect. Window w occupies `prg_bank[6w+5:6w]` and `prg_ext[w]`.
- R4: Program window 3 always reports bank 63 with the external device selected.
- R5: `chr_bank_lo` equals bit 0 of register 5, and `chr_bank_hi` is always 1.
- R6: `mirror_sel` equals the inverse of bit 1 of register 10.
- R7: A write to exactly address 0xDA00 loads `cpu_data[1:0]` into `nt_ctrl`. A write to register 10 at any other address leaves `nt_ctrl` unchanged.
- R8: After reset, every register and `nt_ctrl` are zero. All switchable banks read 0 on the internal device and `mirror_sel` is 1.
- R9: A cycle with `cpu_wr` low, or with `cpu_addr[15]` low, changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one per cycle |
| wram_bank_lo | output | 2 | Bank for the lower 4 KB work-RAM window |
| wram_bank_hi | output | 2 | Bank for the upper 4 KB work-RAM window |
| prg_bank | output | 24 | Four 6-bit program banks, window 0 in the low bits |
| prg_ext | output | 4 | Per program window: 1 = external device |
| chr_bank_lo | output | 1 | Bank for the lower pattern window |
| chr_bank_hi | output | 1 | Bank for the upper pattern window |
| mirror_sel | output | 1 | Nametable mirroring select |
| nt_ctrl | output | 2 | Shadow code for nametable RAM control |

## Verification
A single write to address 0xDA00 does two things at one edge: it stores register 10, which drives `mirror_sel`, and it loads the `nt_ctrl` shadow. The bench issues that write with data whose bit 1 and bits [1:0] both differ from the current state, so both outputs must move together. Writes to register 10 through other addresses, such as 0x9A00 and 0xFA00, must move only the mirroring output. A random phase then hits 0xDA00 among arbitrary traffic, and a behavioural model judges both outputs on every clock.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
   localparam int unsigned CPU_AW        = 16;
   localparam int unsigned CPU_DW        = 8;
   localparam int unsigned CFG_REGS      = 16;
   localparam int unsigned PRG_BW        = 6;
   localparam int unsigned PRG_WINDOWS   = 4;
   localparam int unsigned WRAM_TOTAL_KB = 16;
   localparam int unsigned WRAM_WIN_KB   = 4;
   localparam int unsigned NT_W          = 2;
   localparam int unsigned WRAM_BW       = $clog2(WRAM_TOTAL_KB / WRAM_WIN_KB);
   // register roles; indices are decoded by the mapping logic
   localparam int unsigned IDX_WRAM_LO   = 0;
   localparam int unsigned IDX_WRAM_HI   = 1;
   localparam int unsigned IDX_PRG_FIRST = 2;
   localparam int unsigned IDX_CHR       = 5;
   localparam int unsigned IDX_NT        = 10;
   localparam logic [CPU_AW-1:0] NT_SHADOW_ADDR = 16'hDA00;
endpackage

// File: rtl/cbm_regfile.sv
module cbm_regfile #(
   parameter int unsigned AW          = 16,
   parameter int unsigned DW          = 8,
   parameter int unsigned NREGS       = 16,
   parameter int unsigned NT_W        = 2,
   parameter int unsigned NT_IDX      = 10,
   parameter logic [AW-1:0] SHADOW_AD = 16'hDA00
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [AW-1:0]             addr,
   input  logic [DW-1:0]             data,
   input  logic                      wr,
   output logic [NREGS-1:0][DW-1:0]  regs,
   output logic [NT_W-1:0]           shadow
);
   localparam int unsigned IDX_W  = $clog2(NREGS);
   localparam int unsigned IDX_LO = 8;

   if (IDX_LO + IDX_W > AW - 1) begin : g_bad_idx
      $error("register index field overlaps the window bit");
   end
   if (NT_W > DW) begin : g_bad_nt
      $error("shadow wider than data");
   end

   logic             in_window;
   logic [IDX_W-1:0] idx;
   logic             hit_shadow;

   assign in_window  = wr && addr[AW-1];
   assign idx        = addr[IDX_LO +: IDX_W];
   assign hit_shadow = wr && (addr == SHADOW_AD);

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[i] <= '0;
         else if (in_window && (idx == IDX_W'(i)))
            regs[i] <= data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         shadow <= '0;
      else if (hit_shadow)
         shadow <= data[NT_W-1:0];
   end
endmodule

// File: rtl/cbm_wram_map.sv
module cbm_wram_map #(
   parameter int unsigned DW   = 8,
   parameter int unsigned WBW  = 2,
   parameter int unsigned NWIN = 2
) (
   input  logic [NWIN-1:0][DW-1:0]  cfg,
   output logic [NWIN-1:0][WBW-1:0] bank
);
   if (WBW + 2 > DW) begin : g_bad_w
      $error("work-RAM bank width too large for register");
   end

   logic unused_cfg;
   assign unused_cfg = ^cfg;

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      logic [DW-1:0] folded;
      assign folded  = (cfg[w] & DW'(1)) | (cfg[w] >> 2);
      assign bank[w] = folded[WBW-1:0];
   end
endmodule

// File: rtl/cbm_prg_map.sv
module cbm_prg_map #(
   parameter int unsigned DW   = 8,
   parameter int unsigned BW   = 6,
   parameter int unsigned NWIN = 4
) (
   input  logic [NWIN-2:0][DW-1:0] cfg,
   output logic [NWIN*BW-1:0]      bank,
   output logic [NWIN-1:0]         ext
);
   if (BW + 1 > DW) begin : g_bad_bw
      $error("program bank plus device bit exceed register width");
   end
   if (NWIN < 2) begin : g_bad_n
      $error("need at least one switchable window");
   end

   logic unused_cfg;
   assign unused_cfg = ^cfg;

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      if (w == NWIN - 1) begin : g_fixed
         assign bank[w*BW +: BW] = '1;
         assign ext[w]           = 1'b1;
      end else begin : g_switch
         assign bank[w*BW +: BW] = cfg[w][BW-1:0];
         assign ext[w]           = cfg[w][BW];
      end
   end
endmodule

// File: rtl/cart_bank_map.sv
module cart_bank_map
   import cbm_pkg::*;
(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [CPU_AW-1:0]         cpu_addr,
   input  logic [CPU_DW-1:0]         cpu_data,
   input  logic                      cpu_wr,
   output logic [WRAM_BW-1:0]        wram_bank_lo,
   output logic [WRAM_BW-1:0]        wram_bank_hi,
   output logic [PRG_WINDOWS*PRG_BW-1:0] prg_bank,
   output logic [PRG_WINDOWS-1:0]    prg_ext,
   output logic                      chr_bank_lo,
   output logic                      chr_bank_hi,
   output logic                      mirror_sel,
   output logic [NT_W-1:0]           nt_ctrl
);
   if (IDX_PRG_FIRST + PRG_WINDOWS - 1 > CFG_REGS) begin : g_bad_map
      $error("program registers exceed register count");
   end

   logic [CFG_REGS-1:0][CPU_DW-1:0]    regs;
   logic [1:0][CPU_DW-1:0]             wram_cfg;
   logic [1:0][WRAM_BW-1:0]            wram_bank;
   logic [PRG_WINDOWS-2:0][CPU_DW-1:0] prg_cfg;
   logic                               unused_regs;

   cbm_regfile #(
      .AW(CPU_AW), .DW(CPU_DW), .NREGS(CFG_REGS), .NT_W(NT_W),
      .NT_IDX(IDX_NT), .SHADOW_AD(NT_SHADOW_ADDR)
   ) i_regfile (
      .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .data(cpu_data),
      .wr(cpu_wr), .regs(regs), .shadow(nt_ctrl)
   );

   assign wram_cfg[0] = regs[IDX_WRAM_LO];
   assign wram_cfg[1] = regs[IDX_WRAM_HI];

   cbm_wram_map #(.DW(CPU_DW), .WBW(WRAM_BW), .NWIN(2)) i_wram (
      .cfg(wram_cfg), .bank(wram_bank)
   );
   assign wram_bank_lo = wram_bank[0];
   assign wram_bank_hi = wram_bank[1];

   for (genvar w = 0; w < PRG_WINDOWS - 1; w++) begin : g_prg_cfg
      assign prg_cfg[w] = regs[IDX_PRG_FIRST + w];
   end

   cbm_prg_map #(.DW(CPU_DW), .BW(PRG_BW), .NWIN(PRG_WINDOWS)) i_prg (
      .cfg(prg_cfg), .bank(prg_bank), .ext(prg_ext)
   );

   assign chr_bank_lo = regs[IDX_CHR][0];
   assign chr_bank_hi = 1'b1;
   assign mirror_sel  = ~regs[IDX_NT][1];
   assign unused_regs = ^regs;
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker
   import cbm_pkg::*;
(
   input logic                          clk,
   input logic                          rst_n,
   input logic [CPU_AW-1:0]             cpu_addr,
   input logic [CPU_DW-1:0]             cpu_data,
   input logic                          cpu_wr,
   input logic [WRAM_BW-1:0]            wram_bank_lo,
   input logic [WRAM_BW-1:0]            wram_bank_hi,
   input logic [PRG_WINDOWS*PRG_BW-1:0] prg_bank,
   input logic [PRG_WINDOWS-1:0]        prg_ext,
   input logic                          chr_bank_lo,
   input logic                          chr_bank_hi,
   input logic                          mirror_sel,
   input logic [NT_W-1:0]               nt_ctrl
);
   localparam int unsigned TOP = PRG_WINDOWS - 1;

   logic wr_win;
   assign wr_win = cpu_wr && cpu_addr[CPU_AW-1];

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_win |=> $stable({wram_bank_lo, wram_bank_hi, prg_bank, prg_ext,
                           chr_bank_lo, mirror_sel})); // R9

   AST_WRAM_LO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_win && cpu_addr[11:8] == 4'(IDX_WRAM_LO)) |=>
      wram_bank_lo == {$past(cpu_data[3]), $past(cpu_data[2] | cpu_data[0])}); // R2

   for (genvar w = 0; w < PRG_WINDOWS - 1; w++) begin : g_prg
      AST_PRG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_win && cpu_addr[11:8] == 4'(IDX_PRG_FIRST + w)) |=>
         (prg_bank[w*PRG_BW +: PRG_BW] == $past(cpu_data[PRG_BW-1:0]) &&
          prg_ext[w] == $past(cpu_data[PRG_BW]))); // R3
   end

   AST_TOP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_win |=> (prg_ext[TOP] && (&prg_bank[TOP*PRG_BW +: PRG_BW]))); // R4

   AST_CHR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_win && cpu_addr[11:8] == 4'(IDX_CHR)) |=>
      (chr_bank_lo == $past(cpu_data[0]) && chr_bank_hi)); // R5

   AST_MIRROR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_win && cpu_addr[11:8] == 4'(IDX_NT)) |=>
      mirror_sel == !$past(cpu_data[1])); // R6

   AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr == NT_SHADOW_ADDR) |=>
      nt_ctrl == $past(cpu_data[NT_W-1:0])); // R7

   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_wr && cpu_addr == NT_SHADOW_ADDR) |=> $stable(nt_ctrl)); // R7

   AST_WRAM_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_win && cpu_addr[11:8] == 4'(IDX_WRAM_HI)) |=>
      wram_bank_hi == {$past(cpu_data[3]), $past(cpu_data[2] | cpu_data[0])}); // R2
endmodule

bind cart_bank_map cbm_checker i_cbm_checker (
   .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
   .cpu_wr(cpu_wr), .wram_bank_lo(wram_bank_lo), .wram_bank_hi(wram_bank_hi),
   .prg_bank(prg_bank), .prg_ext(prg_ext), .chr_bank_lo(chr_bank_lo),
   .chr_bank_hi(chr_bank_hi), .mirror_sel(mirror_sel), .nt_ctrl(nt_ctrl)
);

// File: tb/test_cart_bank_map.sv
`timescale 1ns/1ps
module test_cart_bank_map;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_data = '0;
   logic        cpu_wr = 1'b0;
   logic [1:0]  wram_bank_lo, wram_bank_hi;
   logic [23:0] prg_bank;
   logic [3:0]  prg_ext;
   logic        chr_bank_lo, chr_bank_hi, mirror_sel;
   logic [1:0]  nt_ctrl;

   int checks = 0;
   int errors = 0;
   int m_reg[16];
   int m_nt;
   bit done = 1'b0;

   cart_bank_map i_cart_bank_map (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .cpu_wr(cpu_wr), .wram_bank_lo(wram_bank_lo), .wram_bank_hi(wram_bank_hi),
      .prg_bank(prg_bank), .prg_ext(prg_ext), .chr_bank_lo(chr_bank_lo),
      .chr_bank_hi(chr_bank_hi), .mirror_sel(mirror_sel), .nt_ctrl(nt_ctrl)
   );

   always #2.5 clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int fold(input int r);
      return ((r & 1) | (r >> 2)) & 3;
   endfunction

   task automatic compare_all();
      check(wram_bank_lo == 2'(fold(m_reg[0])), "R2 wram lo", wram_bank_lo, fold(m_reg[0]));
      check(wram_bank_hi == 2'(fold(m_reg[1])), "R2 wram hi", wram_bank_hi, fold(m_reg[1]));
      for (int w = 0; w < 3; w++) begin
         check(prg_bank[w*6 +: 6] == 6'(m_reg[2+w] & 63), "R3 prg bank",
               prg_bank[w*6 +: 6], m_reg[2+w] & 63);
         check(prg_ext[w] == 1'((m_reg[2+w] >> 6) & 1), "R3 prg device",
               prg_ext[w], (m_reg[2+w] >> 6) & 1);
      end
      check(prg_bank[23:18] == 6'd63 && prg_ext[3], "R4 top window",
            {prg_ext[3], prg_bank[23:18]}, 'h7F);
      check(chr_bank_lo == 1'(m_reg[5] & 1) && chr_bank_hi, "R5 pattern banks",
            {chr_bank_hi, chr_bank_lo}, 2 | (m_reg[5] & 1));
      check(mirror_sel == 1'(((m_reg[10] >> 1) & 1) ^ 1), "R6 mirror",
            mirror_sel, ((m_reg[10] >> 1) & 1) ^ 1);
      check(nt_ctrl == 2'(m_nt), "R7 shadow", nt_ctrl, m_nt);
   endtask

   // drive after a falling edge, model at the rising edge, compare at the next falling edge
   task automatic cyc(input logic [15:0] a, input logic [7:0] d, input logic w);
      cpu_addr = a; cpu_data = d; cpu_wr = w;
      @(posedge clk);
      if (w && a[15]) m_reg[a[11:8]] = int'(d);
      if (w && a == 16'hDA00) m_nt = int'(d) & 3;
      @(negedge clk);
      compare_all();
   endtask

   task automatic do_reset();
      cpu_wr = 1'b0;
      rst_n = 1'b0;
      for (int i = 0; i < 16; i++) m_reg[i] = 0;
      m_nt = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8: reset state seen at the ports
      check(wram_bank_lo == 0 && wram_bank_hi == 0, "R8 wram reset",
            {wram_bank_hi, wram_bank_lo}, 0);
      check(prg_bank[17:0] == 0 && prg_ext[2:0] == 0, "R8 prg reset",
            {prg_ext[2:0], prg_bank[17:0]}, 0);
      check(mirror_sel && nt_ctrl == 0 && !chr_bank_lo, "R8 mirror/shadow reset",
            {mirror_sel, nt_ctrl, chr_bank_lo}, 'h8);
      compare_all();
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R9: ignored writes
      cyc(16'h6000, 8'hFF, 1'b1);
      cyc(16'h7A00, 8'hFF, 1'b1);
      cyc(16'h8200, 8'hFF, 1'b0);
      cyc(16'hDA00, 8'h03, 1'b0);
      check(prg_bank[5:0] == 0 && nt_ctrl == 0, "R9 no-effect writes", prg_bank[5:0], 0);
      // R2 fold corner values
      cyc(16'h8000, 8'h0D, 1'b1);
      check(wram_bank_lo == 2'd3, "R2 fold 0x0D", wram_bank_lo, 3);
      cyc(16'h8100, 8'h04, 1'b1);
      check(wram_bank_hi == 2'd1, "R2 fold 0x04", wram_bank_hi, 1);
      cyc(16'h8100, 8'h02, 1'b1);
      check(wram_bank_hi == 2'd0, "R2 fold 0x02", wram_bank_hi, 0);
      // R3 device select and ignored bit 7
      cyc(16'h8200, 8'h7F, 1'b1);
      cyc(16'hA300, 8'h41, 1'b1);
      cyc(16'hC400, 8'h80, 1'b1);
      check(prg_bank[17:12] == 0 && !prg_ext[2], "R3 bit7 ignored", prg_bank[17:12], 0);
      // R5
      cyc(16'hF500, 8'hFF, 1'b1);
      // R1: unused registers change nothing
      for (int i = 6; i < 16; i++) if (i != 10) cyc(16'h8000 | 16'(i << 8), 8'hFF, 1'b1);
      // R6/R7 interplay
      cyc(16'h9A00, 8'h02, 1'b1);
      check(!mirror_sel && nt_ctrl == 0, "R7 alias write leaves shadow", nt_ctrl, 0);
      cyc(16'hDA00, 8'h01, 1'b1);
      check(mirror_sel && nt_ctrl == 2'd1, "R7 exact address loads shadow and mirror",
            {mirror_sel, nt_ctrl}, 5);
      cyc(16'hFA00, 8'h02, 1'b1);
      check(!mirror_sel && nt_ctrl == 2'd1, "R7 shadow held", {mirror_sel, nt_ctrl}, 1);
      // random traffic
      for (int n = 0; n < 3000; n++) begin
         logic [15:0] a;
         a = 16'($urandom);
         case ($urandom % 4)
            0: a = 16'hDA00;
            1: a = {1'b1, a[14:12], a[11:8], 8'h00};
            default: ;
         endcase
         cyc(a, 8'($urandom), 1'($urandom));
      end
      // R8 again after a mid-run reset
      do_reset();
      cyc(16'hE400, 8'h55, 1'b1);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule